// File: doc/BRIEF.md
# Pulse-Width Motor Throttle Frame Transmitter

This block turns an 11-bit throttle command into a 16-bit serial frame and drives it out on a single pin. The frame holds the throttle value, a one-shot telemetry-request flag and a 4-bit checksum. Each frame bit is sent as a slot of fixed length. A one is a long high pulse and a zero is a short one, and the line is low for the rest of the slot.

Software writes a throttle value with a load strobe. The block builds the frame at once and keeps it staged. The frame does not go out until a start pulse arrives on an input that is shared by every channel instance, so all the motors of a system change speed in the same cycle. The slot length comes from the clock and bit-rate parameters. An option flips the output polarity for boards that have an inverting driver.

Top module: `pulse_frame_tx`

## Requirements
- R1: When a load is accepted, the frame is built as follows. The 12-bit payload is {throttle[10:0], tflag}, where tflag is the telemetry flag and sits in payload bit 0. The checksum is payload[3:0] ^ payload[7:4] ^ payload[11:8]. The frame is {payload, checksum}, with the checksum in frame bits 3:0.
- R2: Frame bits go out from bit 15 down to bit 0, one slot per bit.
- R3: A slot lasts SLOT = CLK_HZ/BIT_HZ cycles, which is 16 by default. A one is high for SLOT*3/4 cycles (12 by default) and a zero is high for SLOT*3/8 cycles (6 by default). The high time starts at the beginning of the slot, and the line is low for the rest of the slot.
- R4: A pulse on `telem_req` stays pending until the next accepted load. That load sets tflag = 1 and clears the pending request, so the frame after it has tflag = 0.
- R5: While `enable` is low, `load` is ignored, a `sync_start` pulse starts nothing, and a frame staged earlier stays unsent.
- R6: A staged frame starts only on a `sync_start` pulse. `busy` and the first slot begin in the cycle after the edge that samples the pulse.
- R7: `busy` stays high for exactly 16*SLOT cycles per frame.
- R8: `line` equals the non-inverted waveform XOR `invert`. The line rests low when `invert` = 0 and high when `invert` = 1.
- R9: A load accepted while `busy` is high is staged and does not disturb the frame in flight. A `sync_start` pulse while `busy` is high is ignored. The staged frame is sent on the first trigger after the current frame ends.
- R10: After reset, `busy` is 0, the line rests at its idle level, no frame is staged and no telemetry request is pending, so a trigger sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable for load and start |
| throttle | input | 11 | Throttle command |
| load | input | 1 | Load strobe for `throttle` |
| telem_req | input | 1 | One-shot telemetry request |
| invert | input | 1 | Output polarity swap |
| sync_start | input | 1 | Shared start trigger |
| line | output | 1 | Serial output pin |
| busy | output | 1 | High while a frame is being sent |

## Verification
`busy` is sampled one cycle after the trigger edge. Every later result is measured against that same edge. Slot k covers cycles k*SLOT+1 through (k+1)*SLOT after the edge, and `busy` falls after cycle 16*SLOT. The monitor samples on falling clock edges and counts the high cycles of each slot, then turns that count back into a bit at the slot boundary. It compares the bit with the next item of a queue, which the driver filled from its own frame model when it pulsed the trigger. Checks that something must not happen wait several slot lengths and then confirm that `busy` is still low and the queue is still empty.

// File: rtl/pulse_frame_tx.sv
module pulse_frame_tx #(
  parameter int CLK_HZ = 16_000_000,
  parameter int BIT_HZ = 1_000_000,
  parameter int THR_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [THR_W-1:0] throttle,
  input  logic             load,
  input  logic             telem_req,
  input  logic             invert,
  input  logic             sync_start,
  output logic             line,
  output logic             busy
);
  localparam int SLOT = CLK_HZ / BIT_HZ;
  localparam int CW   = $clog2(SLOT);
  localparam int PW   = THR_W + 1;
  localparam int FW   = PW + 4;
  localparam int NIB  = PW / 4;
  localparam int BW   = $clog2(FW);
  localparam int HI1  = SLOT * 3 / 4;
  localparam int HI0  = SLOT * 3 / 8;

  logic          tel_pend, armed;
  logic [FW-1:0] staged, shreg;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [PW-1:0] payload;
  logic [3:0]    csum;

  wire load_ok  = enable & load;
  wire start_ok = enable & sync_start & armed & ~busy;
  wire slot_end = cnt == CW'(SLOT - 1);

  assign payload = {throttle, tel_pend | telem_req};

  always_comb begin
    csum = '0;
    for (int i = 0; i < NIB; i++) csum = csum ^ payload[i*4 +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tel_pend <= 1'b0;
      armed    <= 1'b0;
      staged   <= '0;
    end else begin
      if (start_ok) armed <= 1'b0;
      if (load_ok) begin
        staged   <= {payload, csum};
        armed    <= 1'b1;
        tel_pend <= 1'b0;
      end else if (telem_req) begin
        tel_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (start_ok) begin
      busy  <= 1'b1;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= staged;
    end else if (busy) begin
      if (slot_end) begin
        cnt   <= '0;
        shreg <= shreg << 1;
        if (bitn == BW'(FW - 1)) busy <= 1'b0;
        else bitn <= bitn + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line = invert ^ (busy & (cnt < (shreg[FW-1] ? CW'(HI1) : CW'(HI0))));
endmodule

module pulse_frame_tx_chk #(
  parameter int CLK_HZ = 16_000_000,
  parameter int BIT_HZ = 1_000_000,
  parameter int FW     = 16
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sync_start,
  input logic invert,
  input logic armed,
  input logic busy,
  input logic line,
  input logic slot_end
);
  localparam int FRAME = FW * (CLK_HZ / BIT_HZ);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else run <= busy ? run + 1 : 0;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line == invert); // R8
  AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sync_start && armed && !busy) |=> busy); // R6
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && sync_start)); // R6
  AST_NO_ARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !armed) |=> !armed); // R5
  AST_SLOT_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_end) |-> line == invert); // R3
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    run <= FRAME); // R7
endmodule

bind pulse_frame_tx pulse_frame_tx_chk #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_start(sync_start), .invert(invert),
  .armed(armed), .busy(busy), .line(line), .slot_end(slot_end)
);

// File: tb/test_pulse_frame_tx.sv
module test_pulse_frame_tx;
  localparam int SLOT = 16;
  localparam int HI1 = 12;
  localparam int HI0 = 6;

  logic clk = 0, rst_n = 0, enable = 1, load = 0, telem_req = 0, invert = 0, sync_start = 0;
  logic [10:0] throttle = '0;
  logic line, busy;

  pulse_frame_tx i_pulse_frame_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .throttle(throttle), .load(load),
    .telem_req(telem_req), .invert(invert), .sync_start(sync_start), .line(line), .busy(busy)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic [15:0] staged_m;
  bit armed_m = 0, tel_m = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] build(input logic [10:0] t, input bit f);
    logic [11:0] p;
    p = {t, f};
    return {p, p[3:0] ^ p[7:4] ^ p[11:8]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [10:0] t, input bit treq);
    @(posedge clk); #1;
    throttle = t; load = 1; telem_req = treq;
    if (enable) begin
      staged_m = build(t, tel_m | treq); armed_m = 1; tel_m = 0;
    end else if (treq) tel_m = 1;
    tick(1);
    load = 0; telem_req = 0;
  endtask

  task automatic do_telem();
    @(posedge clk); #1;
    telem_req = 1; tel_m = 1;
    tick(1);
    telem_req = 0;
  endtask

  task automatic fire(input bit in_flight);
    @(posedge clk); #1;
    sync_start = 1;
    if (enable && armed_m && !in_flight) begin
      for (int i = 15; i >= 0; i--) exp_q.push_back(int'(staged_m[i]));
      armed_m = 0;
    end
    tick(1);
    sync_start = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(3);
  endtask

  int n = 0, hi = 0, total = 0;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        total++; n++;
        hi += int'(line ^ invert);
        if (n == SLOT) begin
          int got;
          got = (hi == HI1) ? 1 : (hi == HI0) ? 0 : 2;
          if (exp_q.size() == 0) chk(0, "R6 R5 unexpected slot", got, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(got == e, "R1 R2 R3 slot bit", got, e);
          end
          n = 0; hi = 0;
        end
      end else if (prev_busy) begin
        chk(total == 16 * SLOT, "R7 busy length", total, 16 * SLOT);
        total = 0; n = 0; hi = 0;
      end
      prev_busy = busy;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(busy == 0 && line == 0, "R10 reset outputs", {busy, line}, 0);
    rst_n = 1;
    tick(2);
    fire(0);
    tick(40);
    chk(busy == 0, "R10 nothing staged after reset", busy, 0);

    do_load(11'h000, 0);
    tick(30);
    chk(busy == 0, "R6 no start without trigger", busy, 0);
    fire(0);
    chk(busy == 1, "R6 busy one cycle after trigger", busy, 1);
    chk(line == 1, "R3 slot starts high", line, 1);
    wait_idle();

    do_load(11'h7FF, 0); fire(0); wait_idle();
    do_load(11'h555, 1); fire(0); wait_idle();
    do_load(11'h2AA, 0); fire(0); wait_idle();
    do_load(11'h431, 0); fire(0); wait_idle();

    do_telem();
    tick(5);
    do_load(11'h0F0, 0); fire(0); wait_idle(); // R4 flag set by pending request
    do_load(11'h0F0, 0); fire(0); wait_idle(); // R4 flag cleared

    enable = 0;
    do_load(11'h123, 0);
    enable = 1;
    fire(0);
    tick(50);
    chk(busy == 0 && exp_q.size() == 0, "R5 load ignored when disabled", busy, 0);
    do_load(11'h321, 0);
    enable = 0;
    fire(0);
    tick(50);
    chk(busy == 0, "R5 trigger ignored when disabled", busy, 0);
    enable = 1;
    fire(0);
    wait_idle();

    invert = 1;
    tick(2);
    chk(line == 1, "R8 inverted idle high", line, 1);
    do_load(11'h6C9, 1); fire(0); wait_idle();
    chk(line == 1, "R8 inverted idle after frame", line, 1);
    invert = 0;
    tick(2);
    chk(line == 0, "R8 normal idle low", line, 0);

    do_load(11'h1A5, 0); fire(0);
    tick(50);
    do_load(11'h5E7, 0);
    fire(1);
    tick(20);
    chk(busy == 1, "R9 frame in flight continues", busy, 1);
    wait_idle();
    chk(busy == 0, "R9 trigger during frame ignored", busy, 0);
    fire(0);
    wait_idle();

    chk(exp_q.size() == 0, "R2 all expected slots seen", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule